// File: doc/BRIEF.md
# Event-Condition-Action Rule Engine

This block issues data-movement actions for a memory-access engine that works as a dataflow machine rather than an instruction pipeline. It holds a small table of rules. Each rule waits on a set of event queues, may be gated by a boolean flag at the head of another queue, and then performs one action: a memory load, a memory store, or a move from one queue to another. Control flow such as a loop exit is expressed by a rule whose condition queue holds the result of a compare, instead of by a branch.

The queue storage sits outside the block. The engine sees each queue's non-empty flag, full flag and head value, and it answers with pop strobes and two push channels. One push channel carries move results and the other carries load responses. Memory is a request/response port. Loads carry a tag, so several loads can be in flight at once, and a response that arrives out of order still lands in the right queue. The rule table is a quasi-static input vector made of `NR` packed rule records. In each record, bits [23:22] hold the action (0 none, 1 load, 2 store, 3 move), [21:14] the trigger queue mask, [13] the condition enable, [12:10] the condition queue, [9:7] source A, [6:4] source B, [3:1] the destination and [0] the destination enable. Rule r occupies bits [24r+23 : 24r].

The engine works in a single pass each cycle and has no multi-state sequencer. It decodes the action of the winning rule with a unique case over the action kind. The only state it holds is the tag table: a busy bit and a destination queue for each tag.

Top module: `eca_engine`

## Requirements
- R1: A rule is eligible only when every queue in its trigger mask reports non-empty. A queue that is empty is never popped.
- R2: A rule with the condition enable set fires only while its condition queue is non-empty and bit 0 of that queue's head is 1. When it fires, it also pops the condition queue. When the bit is 0, the rule does not fire and the condition queue is not popped.
- R3: At most one rule fires per cycle. Among the eligible rules, the lowest index wins. A fired rule pops exactly its trigger queues and its condition queue.
- R4: A move rule with the destination enable set pushes the head of source A into the destination queue on the move push channel, in the cycle it fires.
- R5: A move rule with the destination enable clear pops its queues and pushes nothing.
- R6: A load rule raises a memory read (write enable 0) whose address is the head of source A. The read carries the lowest-numbered free tag, and the load pops its trigger queues in the same cycle.
- R7: A load response with a busy tag pushes its data on the load push channel, to the destination recorded for that tag, in the same cycle. It then frees the tag. Responses may return in any order. A response with a free tag pushes nothing.
- R8: A store rule raises a memory write (write enable 1). The address is the head of source A and the data is the head of source B.
- R9: A move rule with the destination enable set, or any load rule, is not eligible while its destination queue is full. A lower-priority rule may fire instead.
- R10: Load and store rules are not eligible while the memory port is not ready.
- R11: A load rule is not eligible while all `NT` tags are busy. It becomes eligible again once a response frees a tag.
- R12: A move push and a load-response push can occur in the same cycle, and both are delivered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rule_cfg | input | NR*24 | Packed rule table |
| q_nempty | input | 8 | Queue non-empty flags |
| q_full | input | 8 | Queue full flags |
| q_head | input | 8*DW | Head values, queue q at [q*DW +: DW] |
| q_pop | output | 8 | Pop strobes |
| mv_push_vld | output | 1 | Move push valid |
| mv_push_idx | output | 3 | Move push queue |
| mv_push_data | output | DW | Move push data |
| ld_push_vld | output | 1 | Load-response push valid |
| ld_push_idx | output | 3 | Load-response push queue |
| ld_push_data | output | DW | Load-response push data |
| mem_req_vld | output | 1 | Memory request valid |
| mem_req_we | output | 1 | 1 = write, 0 = read |
| mem_req_addr | output | DW | Request address |
| mem_req_wdata | output | DW | Write data |
| mem_req_tag | output | TW | Read tag |
| mem_req_rdy | input | 1 | Memory can accept a request |
| mem_rsp_vld | input | 1 | Read response valid |
| mem_rsp_tag | input | TW | Response tag |
| mem_rsp_data | input | DW | Response data |

## Verification
Two events can land in the same cycle: a load response returning, and a move rule firing. Each uses its own push channel. The bench first issues two loads to different destinations. It then returns the second load's response in the same cycle that a move rule becomes eligible. Both pushes are expected in that cycle, each with its own queue index and data. The first load's response is then returned on its own, to show that responses which arrive out of order still reach the destination recorded for their tag.

// File: rtl/eca_pkg.sv
package eca_pkg;
    localparam int Q_N = 8;
    localparam int Q_W = 3;

    typedef enum logic [1:0] {
        OP_NONE  = 2'd0,
        OP_LOAD  = 2'd1,
        OP_STORE = 2'd2,
        OP_MOVE  = 2'd3
    } act_t;

    typedef struct packed {
        act_t             op;
        logic [Q_N-1:0]   trig;
        logic             cond_en;
        logic [Q_W-1:0]   cond_q;
        logic [Q_W-1:0]   src_a;
        logic [Q_W-1:0]   src_b;
        logic [Q_W-1:0]   dst;
        logic             dst_en;
    } rule_t;
endpackage

// File: rtl/eca_rule_eval.sv
module eca_rule_eval
    import eca_pkg::*;
#(
    parameter int NR = 4
) (
    input  rule_t [NR-1:0] rules,
    input  logic [Q_N-1:0] q_nempty,
    input  logic [Q_N-1:0] q_full,
    input  logic [Q_N-1:0] q_flag,
    input  logic           tag_avail,
    input  logic           mem_rdy,
    output logic [NR-1:0]  ready
);
    for (genvar r = 0; r < NR; r++) begin : g_rule
        logic trig_ok, cond_ok;
        assign trig_ok = &(~rules[r].trig | q_nempty);
        assign cond_ok = !rules[r].cond_en ||
                         (q_nempty[rules[r].cond_q] && q_flag[rules[r].cond_q]);
        always_comb begin
            ready[r] = 1'b0;
            unique case (rules[r].op)
                OP_NONE:  ready[r] = 1'b0;
                OP_LOAD:  ready[r] = trig_ok && cond_ok && tag_avail && mem_rdy
                                     && !q_full[rules[r].dst];
                OP_STORE: ready[r] = trig_ok && cond_ok && mem_rdy;
                OP_MOVE:  ready[r] = trig_ok && cond_ok &&
                                     (!rules[r].dst_en || !q_full[rules[r].dst]);
            endcase
        end
    end
endmodule

// File: rtl/eca_arbiter.sv
module eca_arbiter #(
    parameter int N  = 4,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  req,
    output logic [N-1:0]  grant,
    output logic [IW-1:0] idx,
    output logic          any
);
    always_comb begin
        grant = '0;
        idx   = '0;
        any   = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (req[i] && !any) begin
                any      = 1'b1;
                idx      = IW'(i);
                grant[i] = 1'b1;
            end
        end
    end

    // R3
    one_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant) && ((grant & ~req) == '0));
endmodule

// File: rtl/eca_tag_table.sv
module eca_tag_table
    import eca_pkg::*;
#(
    parameter int NT = 4,
    localparam int TW = (NT > 1) ? $clog2(NT) : 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           alloc_vld,
    input  logic [Q_W-1:0] alloc_dst,
    output logic           avail,
    output logic [TW-1:0]  alloc_tag,
    input  logic           rsp_vld,
    input  logic [TW-1:0]  rsp_tag,
    output logic           rsp_hit,
    output logic [Q_W-1:0] rsp_dst
);
    logic [NT-1:0]  busy;
    logic [Q_W-1:0] dstq [NT];

    always_comb begin
        avail     = 1'b0;
        alloc_tag = '0;
        for (int t = 0; t < NT; t++) begin
            if (!busy[t] && !avail) begin
                avail     = 1'b1;
                alloc_tag = TW'(t);
            end
        end
    end

    assign rsp_hit = rsp_vld && busy[rsp_tag];
    assign rsp_dst = dstq[rsp_tag];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= '0;
            for (int t = 0; t < NT; t++) dstq[t] <= '0;
        end else begin
            if (rsp_hit) busy[rsp_tag] <= 1'b0;
            if (alloc_vld) begin
                busy[alloc_tag] <= 1'b1;
                dstq[alloc_tag] <= alloc_dst;
            end
        end
    end

    // R11
    alloc_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_vld |-> (avail && !busy[alloc_tag]));
    // R7
    rsp_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_hit |=> !busy[$past(rsp_tag)]);
endmodule

// File: rtl/eca_engine.sv
module eca_engine
    import eca_pkg::*;
#(
    parameter int NR = 4,
    parameter int DW = 16,
    parameter int NT = 4,
    localparam int TW = (NT > 1) ? $clog2(NT) : 1,
    localparam int RW = $bits(rule_t),
    localparam int IW = (NR > 1) ? $clog2(NR) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NR*RW-1:0] rule_cfg,
    input  logic [Q_N-1:0]   q_nempty,
    input  logic [Q_N-1:0]   q_full,
    input  logic [Q_N*DW-1:0] q_head,
    output logic [Q_N-1:0]   q_pop,
    output logic             mv_push_vld,
    output logic [Q_W-1:0]   mv_push_idx,
    output logic [DW-1:0]    mv_push_data,
    output logic             ld_push_vld,
    output logic [Q_W-1:0]   ld_push_idx,
    output logic [DW-1:0]    ld_push_data,
    output logic             mem_req_vld,
    output logic             mem_req_we,
    output logic [DW-1:0]    mem_req_addr,
    output logic [DW-1:0]    mem_req_wdata,
    output logic [TW-1:0]    mem_req_tag,
    input  logic             mem_req_rdy,
    input  logic             mem_rsp_vld,
    input  logic [TW-1:0]    mem_rsp_tag,
    input  logic [DW-1:0]    mem_rsp_data
);
    rule_t [NR-1:0] rules;
    assign rules = rule_cfg;

    logic [DW-1:0]  head [Q_N];
    logic [Q_N-1:0] flag;
    for (genvar q = 0; q < Q_N; q++) begin : g_head
        assign head[q] = q_head[q*DW +: DW];
        assign flag[q] = q_head[q*DW];
    end

    logic [NR-1:0] ready, grant;
    logic [IW-1:0] gidx;
    logic          any, tag_avail, alloc_vld, rsp_hit;
    logic [TW-1:0] alloc_tag;
    logic [Q_W-1:0] rsp_dst;
    rule_t         sel;

    eca_rule_eval #(.NR(NR)) u_eval (
        .rules(rules), .q_nempty(q_nempty), .q_full(q_full), .q_flag(flag),
        .tag_avail(tag_avail), .mem_rdy(mem_req_rdy), .ready(ready)
    );

    eca_arbiter #(.N(NR)) u_arb (
        .clk(clk), .rst_n(rst_n), .req(ready), .grant(grant), .idx(gidx), .any(any)
    );

    assign sel = rules[gidx];

    eca_tag_table #(.NT(NT)) u_tags (
        .clk(clk), .rst_n(rst_n), .alloc_vld(alloc_vld), .alloc_dst(sel.dst),
        .avail(tag_avail), .alloc_tag(alloc_tag), .rsp_vld(mem_rsp_vld),
        .rsp_tag(mem_rsp_tag), .rsp_hit(rsp_hit), .rsp_dst(rsp_dst)
    );

    always_comb begin
        q_pop         = '0;
        mv_push_vld   = 1'b0;
        mv_push_idx   = sel.dst;
        mv_push_data  = head[sel.src_a];
        mem_req_vld   = 1'b0;
        mem_req_we    = 1'b0;
        mem_req_addr  = head[sel.src_a];
        mem_req_wdata = head[sel.src_b];
        mem_req_tag   = alloc_tag;
        alloc_vld     = 1'b0;
        if (any) begin
            q_pop = sel.trig;
            if (sel.cond_en) q_pop[sel.cond_q] = 1'b1;
            unique case (sel.op)
                OP_NONE:  q_pop = '0;
                OP_LOAD:  begin mem_req_vld = 1'b1; alloc_vld = 1'b1; end
                OP_STORE: begin mem_req_vld = 1'b1; mem_req_we = 1'b1; end
                OP_MOVE:  mv_push_vld = sel.dst_en;
            endcase
        end
    end

    assign ld_push_vld  = rsp_hit;
    assign ld_push_idx  = rsp_dst;
    assign ld_push_data = mem_rsp_data;

    // R1
    pop_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q_pop & ~q_nempty) == '0);
    // R9
    push_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mv_push_vld |-> !q_full[mv_push_idx]);
    // R10
    req_rdy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_vld |-> mem_req_rdy);
    // R2
    cond_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (any && sel.cond_en) |-> flag[sel.cond_q]);
endmodule

// File: tb/sim_eca_engine.sv
module sim_eca_engine;
    import eca_pkg::*;
    localparam int CLK_PERIOD = 10;
    localparam int NR = 4, DW = 16, NT = 4, TW = 2;

    logic clk = 1'b0, rst_n = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    rule_t [NR-1:0] cfg;
    logic [Q_N-1:0] q_nempty, q_full, q_pop;
    logic [DW-1:0]  hv [Q_N];
    logic [Q_N*DW-1:0] q_head;
    logic mv_push_vld, ld_push_vld, mem_req_vld, mem_req_we, mem_req_rdy, mem_rsp_vld;
    logic [Q_W-1:0] mv_push_idx, ld_push_idx;
    logic [DW-1:0] mv_push_data, ld_push_data, mem_req_addr, mem_req_wdata, mem_rsp_data;
    logic [TW-1:0] mem_req_tag, mem_rsp_tag;

    for (genvar q = 0; q < Q_N; q++) begin : g_h
        assign q_head[q*DW +: DW] = hv[q];
    end

    eca_engine #(.NR(NR), .DW(DW), .NT(NT)) u0 (
        .clk(clk), .rst_n(rst_n), .rule_cfg(cfg), .q_nempty(q_nempty), .q_full(q_full),
        .q_head(q_head), .q_pop(q_pop), .mv_push_vld(mv_push_vld), .mv_push_idx(mv_push_idx),
        .mv_push_data(mv_push_data), .ld_push_vld(ld_push_vld), .ld_push_idx(ld_push_idx),
        .ld_push_data(ld_push_data), .mem_req_vld(mem_req_vld), .mem_req_we(mem_req_we),
        .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata), .mem_req_tag(mem_req_tag),
        .mem_req_rdy(mem_req_rdy), .mem_rsp_vld(mem_rsp_vld), .mem_rsp_tag(mem_rsp_tag),
        .mem_rsp_data(mem_rsp_data)
    );

    int total = 0, bad = 0;
    bit done = 0;

    task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", what, act, exp);
        end
    endtask

    function automatic rule_t mk(act_t op, logic [7:0] trig, logic ce, int cq,
                                 int sa, int sb, int d, logic de);
        rule_t r;
        r.op = op; r.trig = trig; r.cond_en = ce; r.cond_q = Q_W'(cq);
        r.src_a = Q_W'(sa); r.src_b = Q_W'(sb); r.dst = Q_W'(d); r.dst_en = de;
        return r;
    endfunction

    task automatic clear();
        cfg = '0; q_nempty = '0; q_full = '0; mem_req_rdy = 1'b1;
        mem_rsp_vld = 1'b0; mem_rsp_tag = '0; mem_rsp_data = '0;
        for (int q = 0; q < Q_N; q++) hv[q] = '0;
    endtask

    task automatic setq(input int q, input logic [DW-1:0] v);
        q_nempty[q] = 1'b1; hv[q] = v;
    endtask

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic sample();
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0; clear(); step(); step(); rst_n = 1'b1;
    endtask

    task automatic t_reset();
        do_reset(); sample();
        chk("R6 reset no request", mem_req_vld, 0);
        chk("R3 reset no pop", q_pop, 0);
        chk("R7 reset no load push", ld_push_vld, 0);
    endtask

    task automatic t_trigger();
        step(); clear();
        cfg[0] = mk(OP_MOVE, 8'b0000_0110, 0, 0, 1, 0, 3, 1);
        setq(1, 16'h1111); sample();
        chk("R1 partial triggers no pop", q_pop, 0);
        chk("R1 partial triggers no push", mv_push_vld, 0);
        step(); setq(2, 16'h2222); sample();
        chk("R1 all triggers pop", q_pop, 8'b0000_0110);
        chk("R4 move push valid", mv_push_vld, 1);
        chk("R4 move push idx", mv_push_idx, 3);
        chk("R4 move push data", mv_push_data, 16'h1111);
    endtask

    task automatic t_cond();
        step(); clear();
        cfg[0] = mk(OP_MOVE, 8'b0000_0001, 1, 4, 0, 0, 2, 1);
        setq(0, 16'h0005); setq(4, 16'h0000); sample();
        chk("R2 false cond no pop", q_pop, 0);
        chk("R2 false cond no push", mv_push_vld, 0);
        step(); hv[4] = 16'h0001; sample();
        chk("R2 true cond pops cond", q_pop, 8'b0001_0001);
        chk("R2 true cond push", mv_push_vld, 1);
    endtask

    task automatic t_prio_full();
        step(); clear();
        cfg[0] = mk(OP_MOVE, 8'b0000_0001, 0, 0, 0, 0, 5, 1);
        cfg[1] = mk(OP_MOVE, 8'b0000_0010, 0, 0, 1, 0, 6, 1);
        setq(0, 16'hAAAA); setq(1, 16'hBBBB); sample();
        chk("R3 lowest index wins pop", q_pop, 8'b0000_0001);
        chk("R3 lowest index wins idx", mv_push_idx, 5);
        step(); q_full[5] = 1'b1; sample();
        chk("R9 full dst stalls rule0", q_pop, 8'b0000_0010);
        chk("R9 lower rule pushes", mv_push_data, 16'hBBBB);
        step(); clear();
        cfg[0] = mk(OP_LOAD, 8'b0000_0001, 0, 0, 0, 0, 5, 0);
        setq(0, 16'h0042); q_full[5] = 1'b1; sample();
        chk("R9 load stalls on full dst", mem_req_vld, 0);
    endtask

    task automatic t_drop();
        step(); clear();
        cfg[2] = mk(OP_MOVE, 8'b0000_1000, 1, 7, 3, 0, 1, 0);
        setq(3, 16'h0009); setq(7, 16'h0001); sample();
        chk("R5 discard pops", q_pop, 8'b1000_1000);
        chk("R5 discard no push", mv_push_vld, 0);
    endtask

    task automatic t_store();
        step(); clear();
        cfg[1] = mk(OP_STORE, 8'b0000_0101, 0, 0, 0, 2, 0, 0);
        setq(0, 16'h0300); setq(2, 16'hCAFE); mem_req_rdy = 1'b0; sample();
        chk("R10 store stalls not ready", mem_req_vld, 0);
        chk("R10 no pop not ready", q_pop, 0);
        step(); mem_req_rdy = 1'b1; sample();
        chk("R8 store valid", mem_req_vld, 1);
        chk("R8 store we", mem_req_we, 1);
        chk("R8 store addr", mem_req_addr, 16'h0300);
        chk("R8 store data", mem_req_wdata, 16'hCAFE);
        chk("R8 store pops", q_pop, 8'b0000_0101);
    endtask

    task automatic t_loads();
        do_reset(); clear();
        cfg[0] = mk(OP_LOAD, 8'b0000_0001, 0, 0, 0, 0, 5, 0);
        cfg[1] = mk(OP_LOAD, 8'b0000_0010, 0, 0, 1, 0, 6, 0);
        cfg[2] = mk(OP_MOVE, 8'b0000_0100, 0, 0, 2, 0, 3, 1);
        setq(0, 16'h0100); sample();
        chk("R6 load valid", mem_req_vld, 1);
        chk("R6 load we", mem_req_we, 0);
        chk("R6 load addr", mem_req_addr, 16'h0100);
        chk("R6 load tag", mem_req_tag, 0);
        chk("R6 load pop", q_pop, 8'b0000_0001);
        step(); q_nempty = '0; setq(1, 16'h0200); sample();
        chk("R6 second load tag", mem_req_tag, 1);
        step(); q_nempty = '0;
        mem_rsp_vld = 1'b1; mem_rsp_tag = 1; mem_rsp_data = 16'hBEEF;
        setq(2, 16'h7777); sample();
        chk("R12 load push valid", ld_push_vld, 1);
        chk("R7 out of order idx", ld_push_idx, 6);
        chk("R7 push data", ld_push_data, 16'hBEEF);
        chk("R12 move push same cycle", mv_push_vld, 1);
        chk("R12 move push data", mv_push_data, 16'h7777);
        step(); q_nempty = '0; mem_rsp_tag = 0; mem_rsp_data = 16'hF00D; sample();
        chk("R7 first tag idx", ld_push_idx, 5);
        chk("R7 first tag data", ld_push_data, 16'hF00D);
        step(); sample();
        chk("R7 freed tag no push", ld_push_vld, 0);
        mem_rsp_vld = 1'b0;
    endtask

    task automatic t_exhaust();
        do_reset(); clear();
        cfg[0] = mk(OP_LOAD, 8'b0000_0001, 0, 0, 0, 0, 4, 0);
        setq(0, 16'h0010);
        for (int k = 0; k < NT; k++) begin
            sample();
            chk("R11 tag sequence", mem_req_tag, k);
            step();
        end
        sample();
        chk("R11 all busy no request", mem_req_vld, 0);
        chk("R11 all busy no pop", q_pop, 0);
        step(); mem_rsp_vld = 1'b1; mem_rsp_tag = 2; step(); mem_rsp_vld = 1'b0; sample();
        chk("R11 freed tag reused", mem_req_vld, 1);
        chk("R11 freed tag value", mem_req_tag, 2);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        clear();
        t_reset();
        t_trigger();
        t_cond();
        t_prio_full();
        t_drop();
        t_store();
        t_loads();
        t_exhaust();
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog act=1 exp=0");
        finish_run();
    end
endmodule